// File: doc/BRIEF.md
# Write-Through Line Controller with Snoop Invalidation

This block keeps coherence state for a small direct-mapped write-through cache on a shared snooping bus. Each line is either valid or invalid, and the tags sit inside the block next to the valid bits. A processor read that misses and every processor write become bus transactions. The block requests the bus, waits for the grant, issues one command cycle, and then waits for the memory acknowledge. The processor sees ready low for the whole of that time. A read hit finishes locally without touching the bus.

The block also watches every transaction on the bus. When another cache writes to a line that this cache holds, with the same index and tag, the line is invalidated. The next local read of that line then fetches fresh data. A run-time policy input chooses what a write miss does. With allocation the line becomes valid after the write; without it the line stays invalid. The policy is captured when the request is accepted. Data storage and multi-beat line transfers are left to the surrounding cache.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After synchronous active-high reset all lines are invalid, `cpu_ready` is 1, and `bus_req`, `bus_cmd_valid` and `cpu_done` are 0.
- R2: A read that misses issues exactly one bus command with opcode 2'b01 (read) at the request address. After `bus_ack` the line is valid with the request's tag.
- R3: A read that hits raises no `bus_req` and no bus command. `cpu_done` rises in the cycle after acceptance, with `cpu_hit` = 1.
- R4: A write that hits issues exactly one bus command with opcode 2'b10 (write), and the line stays valid.
- R5: With `cfg_alloc` = 0 at acceptance, a write that misses issues one write command and leaves the line invalid.
- R6: With `cfg_alloc` = 1 at acceptance, a write that misses issues one write command and, after `bus_ack`, leaves the line valid with the request's tag.
- R7: A snooped command with opcode 2'b10 from an ID other than `CACHE_ID` whose index and tag match a valid line invalidates that line at the next clock edge.
- R8: Snooped commands carrying this cache's own ID, and snooped reads (2'b01) from any ID, change no line state.
- R9: The line index is address bits [IDX_W-1:0] and the tag is the remaining high bits. A valid line with a different tag counts as a miss, and filling the index replaces the stored tag.
- R10: `cpu_ready` is 0 from acceptance until the cycle after `cpu_done`. `bus_req` stays high from the first bus-bound cycle until the acknowledge. A command is issued only in the cycle after a sampled `bus_gnt`.
- R11: `bus_cmd_valid` lasts exactly one cycle per transaction and carries `bus_cmd_id` = `CACHE_ID` and the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_alloc | input | 1 | Write-miss policy: 1 = allocate, 0 = no allocate |
| cpu_req_valid | input | 1 | Processor request present (accepted when `cpu_ready` is 1) |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Request address |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Line hit at acceptance, valid with `cpu_done` |
| bus_req | output | 1 | Bus arbitration request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_valid | output | 1 | Command cycle on the bus |
| bus_cmd_op | output | 2 | 2'b01 read, 2'b10 write, 2'b00 idle |
| bus_cmd_addr | output | ADDR_W | Command address |
| bus_cmd_id | output | ID_W | Requester ID (`CACHE_ID`) |
| bus_ack | input | 1 | Memory completion of the issued command |
| snp_valid | input | 1 | Snooped bus command present |
| snp_op | input | 2 | Snooped opcode |
| snp_addr | input | ADDR_W | Snooped address |
| snp_id | input | ID_W | Snooped requester ID |

## Verification
Reads and writes go to a small pool of addresses: three tags over every index. This gives hits, cold misses and tag conflicts in the same run, so a wrong index or tag split shows up as a mismatched hit flag. Snoops vary the opcode and the requester ID, so a genuine remote invalidation can be told apart from the own-ID and read cases that must be ignored. The allocation policy is flipped between requests, which exposes a policy read at the wrong moment. Grant and acknowledge delays are randomised, which tests whether ready and the single command cycle follow the handshake rather than a fixed latency.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 2;
    localparam int ID_W   = 2;
    localparam int LINES  = 1 << IDX_W;
    localparam int TAG_W  = ADDR_W - IDX_W;

    typedef enum logic [1:0] {
        BUS_NOP = 2'b00,
        BUS_RD  = 2'b01,
        BUS_WR  = 2'b10
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } ctl_state_e;

    typedef struct packed {
        logic              write;
        logic              alloc;
        logic              hit;
        logic [ADDR_W-1:0] addr;
    } req_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/wtc_tag_array.sv
module wtc_tag_array
    import wtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic [TAG_W-1:0] cpu_tag,
    output logic             cpu_hit,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             snp_hit,
    input  logic             inval_en,
    input  logic [IDX_W-1:0] inval_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Fill from our own completed transaction is ordered after a same-cycle snoop.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
            end else if (fill_en && fill_idx == IDX_W'(i)) begin
                valid_q[i] <= 1'b1;
                tag_q[i]   <= fill_tag;
            end else if (inval_en && inval_idx == IDX_W'(i)) begin
                valid_q[i] <= 1'b0;
            end
        end
    end

    assign cpu_hit = valid_q[cpu_idx] && (tag_q[cpu_idx] == cpu_tag);
    assign snp_hit = valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);

    assert_fill_sets_valid_R6: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid_q[$past(fill_idx)]);

    assert_inval_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (inval_en && !(fill_en && fill_idx == inval_idx)) |=> !valid_q[$past(inval_idx)]);
endmodule

// File: rtl/wtc_snoop_filter.sv
module wtc_snoop_filter
    import wtc_pkg::*;
#(
    parameter logic [ID_W-1:0] OWN_ID = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    input  logic              lk_hit,
    output logic              inval_en,
    output logic [IDX_W-1:0]  inval_idx
);
    logic remote_write;

    assign lk_idx       = idx_of(snp_addr);
    assign lk_tag       = tag_of(snp_addr);
    assign remote_write = snp_valid && (snp_op == BUS_WR) && (snp_id != OWN_ID);
    assign inval_en     = remote_write && lk_hit;
    assign inval_idx    = lk_idx;

    assert_own_id_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_id == OWN_ID) |-> !inval_en);

    assert_snoop_read_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_op == BUS_RD) |-> !inval_en);
endmodule

// File: rtl/wtc_req_fsm.sv
module wtc_req_fsm
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_alloc,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic              lk_hit,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd_op,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    input  logic              bus_ack,
    output logic              fill_en,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag
);
    ctl_state_e state_q, state_d;
    req_t       req_q;
    logic       accept;

    assign accept = (state_q == ST_IDLE) && cpu_req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req_valid)
                          state_d = (!cpu_req_write && lk_hit) ? ST_DONE : ST_ARB;
            ST_ARB:   if (bus_gnt) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (bus_ack) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                req_q.write <= cpu_req_write;
                req_q.alloc <= cfg_alloc;
                req_q.hit   <= lk_hit;
                req_q.addr  <= cpu_req_addr;
            end
        end
    end

    assign cpu_ready     = (state_q == ST_IDLE);
    assign cpu_done      = (state_q == ST_DONE);
    assign cpu_hit       = cpu_done && req_q.hit;
    assign bus_req       = (state_q == ST_ARB) || (state_q == ST_ISSUE) || (state_q == ST_WAIT);
    assign bus_cmd_valid = (state_q == ST_ISSUE);
    assign bus_cmd_op    = bus_cmd_valid ? (req_q.write ? BUS_WR : BUS_RD) : BUS_NOP;
    assign bus_cmd_addr  = bus_cmd_valid ? req_q.addr : '0;

    // Reads always fill; writes fill only under the allocate policy.
    assign fill_en  = (state_q == ST_WAIT) && bus_ack && (!req_q.write || req_q.alloc);
    assign fill_idx = idx_of(req_q.addr);
    assign fill_tag = tag_of(req_q.addr);

    assert_cmd_after_grant_R10: assert property (@(posedge clk) disable iff (rst)
        bus_cmd_valid |-> $past(bus_gnt));

    assert_ready_no_bus_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !bus_req);

    assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> bus_req);

    assert_cmd_single_R11: assert property (@(posedge clk) disable iff (rst)
        bus_cmd_valid |=> !bus_cmd_valid);

    assert_read_hit_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req_valid && !cpu_req_write && lk_hit) |=> (cpu_done && !bus_req));

    assert_done_then_ready_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> cpu_ready);
endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl
    import wtc_pkg::*;
#(
    parameter logic [ID_W-1:0] CACHE_ID = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_alloc,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd_op,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    output logic [ID_W-1:0]   bus_cmd_id,
    input  logic              bus_ack,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id
);
    logic             lk_cpu_hit, lk_snp_hit;
    logic [IDX_W-1:0] snp_idx, inval_idx, fill_idx;
    logic [TAG_W-1:0] snp_tag, fill_tag;
    logic             inval_en, fill_en;

    assign bus_cmd_id = bus_cmd_valid ? CACHE_ID : '0;

    wtc_tag_array u_tags (
        .clk       (clk),
        .rst       (rst),
        .cpu_idx   (idx_of(cpu_req_addr)),
        .cpu_tag   (tag_of(cpu_req_addr)),
        .cpu_hit   (lk_cpu_hit),
        .snp_idx   (snp_idx),
        .snp_tag   (snp_tag),
        .snp_hit   (lk_snp_hit),
        .inval_en  (inval_en),
        .inval_idx (inval_idx),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag)
    );

    wtc_snoop_filter #(.OWN_ID(CACHE_ID)) u_snoop (
        .clk       (clk),
        .rst       (rst),
        .snp_valid (snp_valid),
        .snp_op    (snp_op),
        .snp_addr  (snp_addr),
        .snp_id    (snp_id),
        .lk_idx    (snp_idx),
        .lk_tag    (snp_tag),
        .lk_hit    (lk_snp_hit),
        .inval_en  (inval_en),
        .inval_idx (inval_idx)
    );

    wtc_req_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cfg_alloc     (cfg_alloc),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .cpu_req_addr  (cpu_req_addr),
        .lk_hit        (lk_cpu_hit),
        .cpu_ready     (cpu_ready),
        .cpu_done      (cpu_done),
        .cpu_hit       (cpu_hit),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_cmd_valid (bus_cmd_valid),
        .bus_cmd_op    (bus_cmd_op),
        .bus_cmd_addr  (bus_cmd_addr),
        .bus_ack       (bus_ack),
        .fill_en       (fill_en),
        .fill_idx      (fill_idx),
        .fill_tag      (fill_tag)
    );

    assert_id_on_cmd_R11: assert property (@(posedge clk) disable iff (rst)
        bus_cmd_valid |-> (bus_cmd_id == CACHE_ID));

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (cpu_ready && !bus_req && !cpu_done));
endmodule

// File: tb/wt_snoop_ctrl_tb.sv
module wt_snoop_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OWN = 2'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_alloc = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_write = 1'b0;
    logic [11:0] cpu_req_addr = '0;
    logic        cpu_ready, cpu_done, cpu_hit, bus_req, bus_cmd_valid;
    logic [1:0]  bus_cmd_op, bus_cmd_id;
    logic [11:0] bus_cmd_addr;
    logic        bus_gnt = 1'b0;
    logic        bus_ack = 1'b0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_op = '0;
    logic [11:0] snp_addr = '0;
    logic [1:0]  snp_id = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    bit        mval [4];
    logic [9:0] mtag [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_snoop_ctrl #(.CACHE_ID(OWN)) dut_i (
        .clk(clk), .rst(rst), .cfg_alloc(cfg_alloc),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .cpu_hit(cpu_hit), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_cmd_valid(bus_cmd_valid), .bus_cmd_op(bus_cmd_op),
        .bus_cmd_addr(bus_cmd_addr), .bus_cmd_id(bus_cmd_id), .bus_ack(bus_ack),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr), .snp_id(snp_id)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit model_hit(input logic [11:0] a);
        return mval[a[1:0]] && (mtag[a[1:0]] == a[11:2]);
    endfunction

    // Called and returns at a negedge with the controller idle.
    task automatic do_req(input bit wr, input logic [11:0] a);
        bit    exp_hit = model_hit(a);
        string tag;
        int    gd = $urandom_range(0, 3);
        int    ad = $urandom_range(0, 3);
        int    wcnt = 0, acnt = 0, ncmd = 0, guard = 0;
        bit    cmd_seen = 0, ack_sent = 0, done_seen = 0, gnt_given = 0;
        logic [1:0] op_seen = 2'b00;
        if (!wr) tag = exp_hit ? "R3" : "R2";
        else if (exp_hit) tag = "R4";
        else tag = cfg_alloc ? "R6" : "R5";
        chk(cpu_ready == 1'b1, "R10 ready before request", int'(cpu_ready), 1);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk(cpu_ready == 1'b0, "R10 ready low after accept", int'(cpu_ready), 0);
        while (guard < 40) begin
            guard++;
            if (cpu_done) begin
                done_seen = 1;
                bus_gnt = 1'b0;
                bus_ack = 1'b0;
                break;
            end
            if (!wr && exp_hit)
                chk(bus_req == 1'b0, "R3 no bus request on read hit", int'(bus_req), 0);
            if (bus_cmd_valid) begin
                ncmd++;
                op_seen = bus_cmd_op;
                cmd_seen = 1;
                chk(gnt_given, "R10 command only after grant", int'(gnt_given), 1);
                chk(bus_cmd_addr == a, "R11 command address", int'(bus_cmd_addr), int'(a));
                chk(bus_cmd_id == OWN, "R11 command id", int'(bus_cmd_id), int'(OWN));
            end else if (cmd_seen) begin
                chk(bus_req == 1'b1 || ack_sent, "R10 bus_req held to ack", int'(bus_req), 1);
                if (!ack_sent && acnt >= ad) begin
                    bus_ack = 1'b1;
                    ack_sent = 1;
                end else begin
                    bus_ack = 1'b0;
                end
                acnt++;
            end
            if (bus_req && !cmd_seen) begin
                if (wcnt >= gd) begin
                    bus_gnt = 1'b1;
                    gnt_given = 1;
                end
                wcnt++;
            end
            @(negedge clk);
        end
        chk(done_seen, {tag, " completion"}, int'(done_seen), 1);
        chk(cpu_hit == exp_hit, {tag, " hit flag (R9 index/tag split)"}, int'(cpu_hit), int'(exp_hit));
        chk(ncmd == ((!wr && exp_hit) ? 0 : 1), {tag, " bus command count"}, ncmd,
            (!wr && exp_hit) ? 0 : 1);
        if (ncmd == 1)
            chk(op_seen == (wr ? 2'b10 : 2'b01), {tag, " bus opcode"}, int'(op_seen),
                wr ? 2 : 1);
        if (!wr || cfg_alloc) begin
            mval[a[1:0]] = 1'b1;
            mtag[a[1:0]] = a[11:2];
        end
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R10 ready after done", int'(cpu_ready), 1);
    endtask

    task automatic snoop(input logic [1:0] op, input logic [11:0] a, input logic [1:0] id);
        snp_valid = 1'b1;
        snp_op    = op;
        snp_addr  = a;
        snp_id    = id;
        if (op == 2'b10 && id != OWN && model_hit(a)) mval[a[1:0]] = 1'b0;
        @(negedge clk);
        snp_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [11:0] mk(input int t, input int i);
        return {10'(t), 2'(i)};
    endfunction

    initial begin
        void'($urandom(32'h5eed_2024));
        for (int i = 0; i < 4; i++) begin
            mval[i] = 1'b0;
            mtag[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R1 ready after reset", int'(cpu_ready), 1);
        chk(bus_req == 1'b0, "R1 no bus request after reset", int'(bus_req), 0);
        chk(bus_cmd_valid == 1'b0 && cpu_done == 1'b0, "R1 idle outputs", int'(cpu_done), 0);

        // Directed corner cases
        do_req(0, mk(5, 2));            // R1/R2 cold miss
        do_req(0, mk(5, 2));            // R3 hit
        snoop(2'b10, mk(5, 2), OWN);    // R8 own id ignored
        do_req(0, mk(5, 2));
        snoop(2'b01, mk(5, 2), 2'd2);   // R8 snooped read ignored
        do_req(0, mk(5, 2));
        do_req(1, mk(5, 2));            // R4 write hit
        do_req(0, mk(5, 2));
        snoop(2'b10, mk(6, 2), 2'd3);   // R9 tag mismatch: no invalidation
        do_req(0, mk(5, 2));
        snoop(2'b10, mk(5, 2), 2'd0);   // R7 remote write invalidates
        do_req(0, mk(5, 2));
        cfg_alloc = 1'b0;
        do_req(1, mk(7, 1));            // R5 no-allocate write miss
        do_req(0, mk(7, 1));
        cfg_alloc = 1'b1;
        do_req(1, mk(8, 3));            // R6 allocate write miss
        do_req(0, mk(8, 3));
        do_req(0, mk(9, 3));            // R9 conflict replaces tag
        do_req(0, mk(8, 3));

        // Constrained random mix
        for (int k = 0; k < 300; k++) begin
            int r = $urandom_range(0, 9);
            logic [11:0] a = mk($urandom_range(0, 2), $urandom_range(0, 3));
            if (r < 2) snoop(2'($urandom_range(1, 2)), a, 2'($urandom_range(0, 3)));
            else if (r == 2) cfg_alloc = ~cfg_alloc;
            else do_req(r < 6, a);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule